// File: doc/BRIEF.md
# Queue Head Transaction Eligibility Gate

This block sits in a USB host controller's schedule walker. It decides whether an active queue head may start a transaction in the current microframe, and it carries out the bookkeeping that must happen first. The walker pulses `start_i` with the fields of one queue head on the inputs. One cycle later the block answers with a `done_o` pulse, and that pulse carries the verdict and any write-backs.

A non-zero microframe schedule mask marks a periodic (interrupt) head. Such a head is admitted only in the microframes that its mask selects. A zero mask marks an asynchronous head. Such a head is throttled by its NAK counter, which is first refilled from its reload value when a refill is pending. For either kind, the high-bandwidth multiplier is copied into an internal transaction down-counter. A multiplier of zero still loads, but it raises a configuration-error flag.

Top module: `qh_eligibility`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o`, `eligible_o`, `nak_we_o`, `reload_clr_o`, `xact_ld_o` and `cfg_err_o` are 0, and `nak_cnt_o` and `xact_cnt_o` are 0.
- R2: Every `start_i` pulse produces `done_o`=1 on the next cycle. If `active_i` was 0 at the start, then `eligible_o`, `nak_we_o`, `reload_clr_o`, `xact_ld_o` and `cfg_err_o` are 0, and `nak_cnt_o` and `xact_cnt_o` keep their values.
- R3: A head with a non-zero `smask_i` is periodic. Its `eligible_o` equals bit `uframe_i` of `smask_i`, so mask 8'b0010_0000 passes only when `uframe_i`=3'b101. It never asserts `nak_we_o` or `reload_clr_o`, and `nak_cnt_o` is left unchanged.
- R4: For an active head with `smask_i`=0 and `reload_pend_i`=1, `nak_cnt_o` becomes `nak_rl_i`, and `nak_we_o` and `reload_clr_o` are both 1. With `reload_pend_i`=0, `nak_cnt_o` becomes `nak_cnt_i` and both strobes are 0.
- R5: For an active head with `smask_i`=0, `eligible_o` is 1 exactly when the counter after any refill is non-zero or `nak_rl_i` is zero.
- R6: For an active periodic head, `xact_ld_o`=1 and `xact_cnt_o` equals `mult_i`.
- R7: For an active asynchronous head, `xact_ld_o` is 1 and `xact_cnt_o` equals `mult_i` when parameter `ASYNC_MULT_LOAD` is 1 (the default). When that parameter is 0, `xact_ld_o` is 0 and `xact_cnt_o` keeps its value.
- R8: `cfg_err_o` is 1 exactly when `xact_ld_o` is 1 and the loaded `mult_i` was 0.
- R9: In a cycle that follows no `start_i`, all six strobes are 0 and `nak_cnt_o` and `xact_cnt_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Evaluate the presented queue head |
| active_i | input | 1 | Queue head active status bit |
| smask_i | input | MASK_W | Microframe schedule mask |
| nak_cnt_i | input | NAK_W | Current NAK counter |
| nak_rl_i | input | NAK_W | NAK counter reload value |
| reload_pend_i | input | 1 | NAK counter refill pending |
| mult_i | input | MULT_W | High-bandwidth multiplier |
| uframe_i | input | $clog2(MASK_W) | Low bits of the frame index |
| done_o | output | 1 | Result strobe, one cycle after start |
| eligible_o | output | 1 | Head may issue a transaction |
| nak_cnt_o | output | NAK_W | Updated NAK counter value |
| nak_we_o | output | 1 | Write `nak_cnt_o` back to the head |
| reload_clr_o | output | 1 | Clear the refill-pending flag |
| xact_cnt_o | output | MULT_W | Transaction down-counter value |
| xact_ld_o | output | 1 | Down-counter was loaded |
| cfg_err_o | output | 1 | Loaded multiplier was zero |

## Verification
Every non-zero mask is swept against all eight microframe indices. This separates correct bit selection from off-by-one or reversed indexing, and it shows that periodic heads ignore the NAK inputs even when a refill is pending. Asynchronous heads are swept over every pair of counter and reload value, both with and without a pending refill. That sweep tells apart a check made before the refill from one made after it, and it exercises the zero-reload bypass. Inactive heads and idle cycles between runs confirm that no strobe fires and no held value moves.

// File: rtl/qh_pkg.sv
package qh_pkg;

    typedef struct packed {
        logic done;
        logic elig;
        logic nak_we;
        logic rl_clr;
        logic x_ld;
        logic cfg_err;
    } qh_strobe_t;

    localparam qh_strobe_t QH_STROBE_IDLE = '{default: 1'b0};

endpackage

// File: rtl/qh_intr_gate.sv
module qh_intr_gate #(
    parameter int MASK_W = 8,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] smask,
    input  logic [IDX_W-1:0]  uframe,
    output logic              is_periodic,
    output logic              slot_hit
);
    logic [MASK_W-1:0] slot_sel;

    for (genvar g = 0; g < MASK_W; g++) begin : g_slot
        assign slot_sel[g] = (uframe == IDX_W'(g));
    end

    assign is_periodic = |smask;
    assign slot_hit    = |(slot_sel & smask);
endmodule

// File: rtl/qh_nak_throttle.sv
module qh_nak_throttle #(
    parameter int NAK_W = 4
) (
    input  logic [NAK_W-1:0] nak_cnt,
    input  logic [NAK_W-1:0] nak_rl,
    input  logic             refill_pend,
    output logic [NAK_W-1:0] nak_next,
    output logic             refill_now,
    output logic             pass
);
    logic throttle_off;

    assign refill_now   = refill_pend;
    assign nak_next     = refill_pend ? nak_rl : nak_cnt;
    assign throttle_off = (nak_rl == '0);
    assign pass         = (nak_next != '0) || throttle_off;
endmodule

// File: rtl/qh_mult_load.sv
module qh_mult_load #(
    parameter int MULT_W          = 2,
    parameter bit ASYNC_MULT_LOAD = 1'b1
) (
    input  logic              en,
    input  logic              is_periodic,
    input  logic [MULT_W-1:0] mult,
    output logic              load,
    output logic [MULT_W-1:0] value,
    output logic              zero_err
);
    if (ASYNC_MULT_LOAD) begin : g_load_all
        assign load = en;
    end else begin : g_load_periodic
        assign load = en && is_periodic;
    end

    assign value    = mult;
    assign zero_err = load && (mult == '0);
endmodule

// File: rtl/qh_eligibility.sv
module qh_eligibility
    import qh_pkg::*;
#(
    parameter int MASK_W          = 8,
    parameter int NAK_W           = 4,
    parameter int MULT_W          = 2,
    parameter bit ASYNC_MULT_LOAD = 1'b1,
    localparam int IDX_W          = $clog2(MASK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              active_i,
    input  logic [MASK_W-1:0] smask_i,
    input  logic [NAK_W-1:0]  nak_cnt_i,
    input  logic [NAK_W-1:0]  nak_rl_i,
    input  logic              reload_pend_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [IDX_W-1:0]  uframe_i,
    output logic              done_o,
    output logic              eligible_o,
    output logic [NAK_W-1:0]  nak_cnt_o,
    output logic              nak_we_o,
    output logic              reload_clr_o,
    output logic [MULT_W-1:0] xact_cnt_o,
    output logic              xact_ld_o,
    output logic              cfg_err_o
);

    typedef struct packed {
        qh_strobe_t        stb;
        logic [NAK_W-1:0]  nak;
        logic [MULT_W-1:0] xcnt;
    } state_t;

    state_t st_d, st_q;

    logic              is_periodic, slot_hit;
    logic [NAK_W-1:0]  nak_next;
    logic              refill_now, nak_pass;
    logic              go;
    logic              ml_load, ml_err;
    logic [MULT_W-1:0] ml_value;

    assign go = start_i && active_i;

    qh_intr_gate #(.MASK_W(MASK_W)) u_intr_gate (
        .smask       (smask_i),
        .uframe      (uframe_i),
        .is_periodic (is_periodic),
        .slot_hit    (slot_hit)
    );

    qh_nak_throttle #(.NAK_W(NAK_W)) u_nak_throttle (
        .nak_cnt     (nak_cnt_i),
        .nak_rl      (nak_rl_i),
        .refill_pend (reload_pend_i),
        .nak_next    (nak_next),
        .refill_now  (refill_now),
        .pass        (nak_pass)
    );

    qh_mult_load #(
        .MULT_W          (MULT_W),
        .ASYNC_MULT_LOAD (ASYNC_MULT_LOAD)
    ) u_mult_load (
        .en          (go),
        .is_periodic (is_periodic),
        .mult        (mult_i),
        .load        (ml_load),
        .value       (ml_value),
        .zero_err    (ml_err)
    );

    always_comb begin
        st_d          = st_q;
        st_d.stb      = QH_STROBE_IDLE;
        st_d.stb.done = start_i;
        if (go) begin
            if (is_periodic) begin
                st_d.stb.elig = slot_hit;
            end else begin
                st_d.stb.elig   = nak_pass;
                st_d.stb.nak_we = refill_now;
                st_d.stb.rl_clr = refill_now;
                st_d.nak        = nak_next;
            end
            if (ml_load) begin
                st_d.stb.x_ld    = 1'b1;
                st_d.stb.cfg_err = ml_err;
                st_d.xcnt        = ml_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o       = st_q.stb.done;
    assign eligible_o   = st_q.stb.elig;
    assign nak_we_o     = st_q.stb.nak_we;
    assign reload_clr_o = st_q.stb.rl_clr;
    assign xact_ld_o    = st_q.stb.x_ld;
    assign cfg_err_o    = st_q.stb.cfg_err;
    assign nak_cnt_o    = st_q.nak;
    assign xact_cnt_o   = st_q.xcnt;

endmodule

// File: rtl/qh_eligibility_chk.sv
module qh_eligibility_chk #(
    parameter int MASK_W          = 8,
    parameter int NAK_W           = 4,
    parameter int MULT_W          = 2,
    parameter bit ASYNC_MULT_LOAD = 1'b1,
    localparam int IDX_W          = $clog2(MASK_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              active_i,
    input logic [MASK_W-1:0] smask_i,
    input logic [NAK_W-1:0]  nak_cnt_i,
    input logic [NAK_W-1:0]  nak_rl_i,
    input logic              reload_pend_i,
    input logic [MULT_W-1:0] mult_i,
    input logic [IDX_W-1:0]  uframe_i,
    input logic              done_o,
    input logic              eligible_o,
    input logic [NAK_W-1:0]  nak_cnt_o,
    input logic              nak_we_o,
    input logic              reload_clr_o,
    input logic [MULT_W-1:0] xact_cnt_o,
    input logic              xact_ld_o,
    input logic              cfg_err_o
);

    p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    p_inactive_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !active_i) |=> (!eligible_o && !nak_we_o && !reload_clr_o && !xact_ld_o));

    p_periodic_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_i && (smask_i != '0))
        |=> (eligible_o == $past(smask_i[uframe_i]) && !nak_we_o && $stable(nak_cnt_o)));

    p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_i && (smask_i == '0) && reload_pend_i)
        |=> (nak_we_o && reload_clr_o && nak_cnt_o == $past(nak_rl_i)));

    p_async_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_i && (smask_i == '0))
        |=> (eligible_o == ((($past(reload_pend_i) ? $past(nak_rl_i) : $past(nak_cnt_i)) != '0)
                            || ($past(nak_rl_i) == '0))));

    p_mult_periodic_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_i && (smask_i != '0))
        |=> (xact_ld_o && xact_cnt_o == $past(mult_i)));

    p_mult_async_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && active_i && (smask_i == '0)) |=> (xact_ld_o == ASYNC_MULT_LOAD));

    p_cfg_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (xact_ld_o && xact_cnt_o == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && !eligible_o && !nak_we_o && !xact_ld_o && !cfg_err_o
                      && $stable(nak_cnt_o) && $stable(xact_cnt_o)));

endmodule

bind qh_eligibility qh_eligibility_chk #(
    .MASK_W          (MASK_W),
    .NAK_W           (NAK_W),
    .MULT_W          (MULT_W),
    .ASYNC_MULT_LOAD (ASYNC_MULT_LOAD)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .active_i      (active_i),
    .smask_i       (smask_i),
    .nak_cnt_i     (nak_cnt_i),
    .nak_rl_i      (nak_rl_i),
    .reload_pend_i (reload_pend_i),
    .mult_i        (mult_i),
    .uframe_i      (uframe_i),
    .done_o        (done_o),
    .eligible_o    (eligible_o),
    .nak_cnt_o     (nak_cnt_o),
    .nak_we_o      (nak_we_o),
    .reload_clr_o  (reload_clr_o),
    .xact_cnt_o    (xact_cnt_o),
    .xact_ld_o     (xact_ld_o),
    .cfg_err_o     (cfg_err_o)
);

// File: tb/qh_eligibility_tb_top.sv
module qh_eligibility_tb_top;

    localparam int MASK_W = 8;
    localparam int NAK_W  = 4;
    localparam int MULT_W = 2;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              active_i = 1'b0;
    logic [MASK_W-1:0] smask_i = '0;
    logic [NAK_W-1:0]  nak_cnt_i = '0;
    logic [NAK_W-1:0]  nak_rl_i = '0;
    logic              reload_pend_i = 1'b0;
    logic [MULT_W-1:0] mult_i = '0;
    logic [IDX_W-1:0]  uframe_i = '0;
    logic              done_o, eligible_o, nak_we_o, reload_clr_o, xact_ld_o, cfg_err_o;
    logic [NAK_W-1:0]  nak_cnt_o;
    logic [MULT_W-1:0] xact_cnt_o;

    int checks = 0;
    int errors = 0;
    logic [NAK_W-1:0]  held_nak = '0;
    logic [MULT_W-1:0] held_xc  = '0;

    always #5 clk = ~clk;

    qh_eligibility dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .active_i (active_i),
        .smask_i (smask_i), .nak_cnt_i (nak_cnt_i), .nak_rl_i (nak_rl_i),
        .reload_pend_i (reload_pend_i), .mult_i (mult_i), .uframe_i (uframe_i),
        .done_o (done_o), .eligible_o (eligible_o), .nak_cnt_o (nak_cnt_o),
        .nak_we_o (nak_we_o), .reload_clr_o (reload_clr_o), .xact_cnt_o (xact_cnt_o),
        .xact_ld_o (xact_ld_o), .cfg_err_o (cfg_err_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input bit act, input logic [MASK_W-1:0] sm,
                           input logic [NAK_W-1:0] nk, input logic [NAK_W-1:0] rl,
                           input bit pend, input logic [MULT_W-1:0] ml,
                           input logic [IDX_W-1:0] uf);
        bit periodic;
        bit e_elig, e_we, e_ld;
        logic [NAK_W-1:0] eff;
        periodic = (sm != '0);
        e_elig = 1'b0; e_we = 1'b0; e_ld = 1'b0;
        if (act) begin
            e_ld = 1'b1;
            if (periodic) begin
                e_elig = sm[uf];
            end else begin
                eff      = pend ? rl : nk;
                e_we     = pend;
                e_elig   = (eff != 0) || (rl == 0);
                held_nak = eff;
            end
            held_xc = ml;
        end
        @(negedge clk);
        start_i = 1'b1; active_i = act; smask_i = sm; nak_cnt_i = nk;
        nak_rl_i = rl; reload_pend_i = pend; mult_i = ml; uframe_i = uf;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b1, "R2 done", int'(done_o), 1);
        if (!act) begin
            chk(!eligible_o && !nak_we_o && !reload_clr_o && !xact_ld_o && !cfg_err_o,
                "R2 inactive strobes", int'({eligible_o, nak_we_o, reload_clr_o, xact_ld_o, cfg_err_o}), 0);
        end else if (periodic) begin
            chk(eligible_o == e_elig, "R3 slot gate", int'(eligible_o), int'(e_elig));
            chk(!nak_we_o && !reload_clr_o, "R3 no nak write", int'({nak_we_o, reload_clr_o}), 0);
            chk(xact_ld_o && xact_cnt_o == ml, "R6 mult load", int'(xact_cnt_o), int'(ml));
        end else begin
            chk(nak_we_o == e_we && reload_clr_o == e_we, "R4 refill strobes",
                int'({nak_we_o, reload_clr_o}), int'({e_we, e_we}));
            chk(eligible_o == e_elig, "R5 nak throttle", int'(eligible_o), int'(e_elig));
            chk(xact_ld_o && xact_cnt_o == ml, "R7 async mult load", int'(xact_cnt_o), int'(ml));
        end
        chk(nak_cnt_o == held_nak, "R4 nak value", int'(nak_cnt_o), int'(held_nak));
        chk(xact_cnt_o == held_xc, "R6 xact value", int'(xact_cnt_o), int'(held_xc));
        chk(cfg_err_o == (e_ld && ml == 0), "R8 cfg err", int'(cfg_err_o), int'(e_ld && ml == 0));
        @(negedge clk);
        chk(!done_o && !eligible_o && !nak_we_o && !reload_clr_o && !xact_ld_o && !cfg_err_o,
            "R9 idle strobes", int'({done_o, eligible_o, nak_we_o, reload_clr_o, xact_ld_o, cfg_err_o}), 0);
        chk(nak_cnt_o == held_nak && xact_cnt_o == held_xc, "R9 held values",
            int'({nak_cnt_o, xact_cnt_o}), int'({held_nak, held_xc}));
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        chk(!done_o && !eligible_o && !nak_we_o && !xact_ld_o && !cfg_err_o && !reload_clr_o,
            "R1 reset strobes", int'({done_o, eligible_o, nak_we_o, xact_ld_o, cfg_err_o}), 0);
        chk(nak_cnt_o == 0 && xact_cnt_o == 0, "R1 reset values", int'({nak_cnt_o, xact_cnt_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && nak_cnt_o == 0 && xact_cnt_o == 0, "R1 after reset",
            int'({done_o, nak_cnt_o, xact_cnt_o}), 0);
        // R3 R6 R8: every non-zero mask against every microframe
        for (int m = 1; m < 256; m++) begin
            for (int u = 0; u < 8; u++) begin
                run_one(1'b1, MASK_W'(m), NAK_W'(m), NAK_W'(m >> 4), m[0],
                        MULT_W'(m + u), IDX_W'(u));
            end
        end
        // R4 R5 R7 R8: every counter / reload pair, refill pending or not
        for (int n = 0; n < 16; n++) begin
            for (int r = 0; r < 16; r++) begin
                for (int p = 0; p < 2; p++) begin
                    run_one(1'b1, '0, NAK_W'(n), NAK_W'(r), p[0], MULT_W'(n + r), IDX_W'(r));
                end
            end
        end
        // R2: inactive heads of both kinds, with refill pending
        for (int k = 0; k < 8; k++) begin
            run_one(1'b0, (k < 4) ? MASK_W'(1 << k) : '0, NAK_W'(k), NAK_W'(15 - k),
                    1'b1, MULT_W'(k), IDX_W'(k));
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule